// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block turns a short SMBus host transaction (quick, send/receive byte, byte-data or word-data) into the ordered list of byte-level operations that a downstream byte master carries out. Software-side logic presents a transaction type, a direction flag, a 7-bit slave address, a command byte and two write data bytes, then pulses a start input. The sequencer then asks the byte master for one operation at a time: start, write byte, read byte, repeated start or stop. It waits for each to complete before asking for the next.

Read results land in two data registers: the low byte in data0 and the high byte in data1. Three sticky status flags report the outcome. Completion is set on success. Device error is set when a written byte is not acknowledged. Collision is set when arbitration is lost. Any error abandons the remaining bytes, issues a stop and returns the block to idle. The status flags clear when the next transaction is accepted.

Top module: `smbus_xact_seq`

## Requirements
- R1: After reset the block is idle: busy is 0, no byte operation is requested, all three status flags are 0, and data0 and data1 are 0.
- R2: Transaction type 0 (quick) requests start, then one write of the address byte {slave_addr, rd_not_wr}, then stop. The byte-master operation codes are 1 start, 2 write, 3 read, 4 repeated start and 5 stop. Every accepted transaction begins with start.
- R3: Type 1 (byte) writes the address byte and then cmd_byte when rd_not_wr=0. When rd_not_wr=1 it writes the address byte with bit 0 set, reads one byte with bm_rd_nack=1, and stores that byte in data0. Both directions end with stop.
- R4: Type 2 (byte-data) with rd_not_wr=0 writes the address byte with bit 0 clear, then cmd_byte, then data0, then stops.
- R5: Type 2 with rd_not_wr=1 writes the address byte with bit 0 clear and then cmd_byte. It then requests a repeated start, writes the address byte with bit 0 set, reads one byte with bm_rd_nack=1 into data0, and stops.
- R6: Type 3 (word) sends data0 before data1 on a write. On a read, after the same lead-in as R5, the first byte is read with bm_rd_nack=0 into data0 and the second with bm_rd_nack=1 into data1.
- R7: A write operation that completes with bm_ack=0 sets dev_err_sts. The next request is stop, no further data bytes are sent, busy then falls, and done_sts stays 0.
- R8: An operation that completes with bm_arb_lost=1 sets coll_sts. The next request is stop, unless the lost operation was itself the stop. Busy then falls and done_sts stays 0.
- R9: done_sts is set only when the final stop completes with no error. Accepting a new transaction clears all three status flags and loads wdata0/wdata1 into data0/data1.
- R10: A go pulse while busy is ignored, and the transaction in progress continues unchanged.
- R11: bm_req, bm_op, bm_wbyte and bm_rd_nack hold steady from the cycle a request is raised until the cycle bm_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse; sampled only when idle |
| xact_type | input | 2 | 0 quick, 1 byte, 2 byte-data, 3 word |
| rd_not_wr | input | 1 | 1 = read transaction |
| slave_addr | input | ADDR_W | 7-bit slave address |
| cmd_byte | input | DATA_W | Command byte |
| wdata0 | input | DATA_W | Write data low byte, loaded into data0 at start |
| wdata1 | input | DATA_W | Write data high byte, loaded into data1 at start |
| data0 | output | DATA_W | Data register 0 (low byte) |
| data1 | output | DATA_W | Data register 1 (high byte) |
| busy | output | 1 | Transaction in progress |
| done_sts | output | 1 | Successful completion flag |
| dev_err_sts | output | 1 | Missing acknowledge flag |
| coll_sts | output | 1 | Arbitration lost flag |
| bm_req | output | 1 | Operation request to byte master |
| bm_op | output | 3 | Operation code |
| bm_wbyte | output | DATA_W | Byte to write |
| bm_rd_nack | output | 1 | Nack the byte being read |
| bm_done | input | 1 | Current operation complete |
| bm_ack | input | 1 | Slave acknowledged the written byte |
| bm_arb_lost | input | 1 | Arbitration lost during the operation |
| bm_rbyte | input | DATA_W | Byte returned by a read |

## Verification
The assertions check on every cycle that a pending request stays steady until it is accepted and that no request appears while idle. They also check that a missing acknowledge or lost arbitration is followed at once by a stop request with the matching flag set, that an accepted stop returns the block to idle, and that completion never coexists with an error flag or with busy. Only the bench scenarios can show that each transaction type produces the right operation order. The same holds for the address byte, the command and data bytes, the nack on the final read byte, the destination register of read data, and a go pulse during a transaction leaving that transaction untouched.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

  typedef enum logic [1:0] {
    XT_QUICK = 2'd0,
    XT_BYTE  = 2'd1,
    XT_BDATA = 2'd2,
    XT_WORD  = 2'd3
  } xact_e;

  typedef enum logic [2:0] {
    BOP_IDLE   = 3'd0,
    BOP_START  = 3'd1,
    BOP_WRITE  = 3'd2,
    BOP_READ   = 3'd3,
    BOP_RSTART = 3'd4,
    BOP_STOP   = 3'd5
  } bop_e;

  // Where a written byte comes from
  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_ADDR    = 3'd1,  // address with the requested direction
    SRC_ADDR_WR = 3'd2,  // address with direction forced to write
    SRC_ADDR_RD = 3'd3,  // address with direction forced to read
    SRC_CMD     = 3'd4,
    SRC_D0      = 3'd5,
    SRC_D1      = 3'd6
  } src_e;

  // Where a read byte goes
  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_D0   = 2'd1,
    DST_D1   = 2'd2
  } dst_e;

  typedef struct packed {
    bop_e op;
    src_e src;
    dst_e dst;
    logic nack;
  } step_t;

  localparam step_t S_START   = '{op: BOP_START,  src: SRC_NONE,    dst: DST_NONE, nack: 1'b0};
  localparam step_t S_RSTART  = '{op: BOP_RSTART, src: SRC_NONE,    dst: DST_NONE, nack: 1'b0};
  localparam step_t S_STOP    = '{op: BOP_STOP,   src: SRC_NONE,    dst: DST_NONE, nack: 1'b0};
  localparam step_t S_WADDR   = '{op: BOP_WRITE,  src: SRC_ADDR,    dst: DST_NONE, nack: 1'b0};
  localparam step_t S_WADDR_W = '{op: BOP_WRITE,  src: SRC_ADDR_WR, dst: DST_NONE, nack: 1'b0};
  localparam step_t S_WADDR_R = '{op: BOP_WRITE,  src: SRC_ADDR_RD, dst: DST_NONE, nack: 1'b0};
  localparam step_t S_WCMD    = '{op: BOP_WRITE,  src: SRC_CMD,     dst: DST_NONE, nack: 1'b0};
  localparam step_t S_WD0     = '{op: BOP_WRITE,  src: SRC_D0,      dst: DST_NONE, nack: 1'b0};
  localparam step_t S_WD1     = '{op: BOP_WRITE,  src: SRC_D1,      dst: DST_NONE, nack: 1'b0};
  localparam step_t S_RD0_ACK = '{op: BOP_READ,   src: SRC_NONE,    dst: DST_D0,   nack: 1'b0};
  localparam step_t S_RD0_NAK = '{op: BOP_READ,   src: SRC_NONE,    dst: DST_D0,   nack: 1'b1};
  localparam step_t S_RD1_NAK = '{op: BOP_READ,   src: SRC_NONE,    dst: DST_D1,   nack: 1'b1};

endpackage

// File: rtl/smb_step_decode.sv
module smb_step_decode
  import smb_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  xact_e             xtype,
  input  logic              rd,
  input  logic [STEP_W-1:0] idx,
  output step_t             step
);

  // Each protocol is a short fixed list; anything past the end is a stop.
  always_comb begin
    step = S_STOP;
    case (xtype)
      XT_QUICK: begin
        case (int'(idx))
          0:       step = S_START;
          1:       step = S_WADDR;
          default: step = S_STOP;
        endcase
      end
      XT_BYTE: begin
        if (rd) begin
          case (int'(idx))
            0:       step = S_START;
            1:       step = S_WADDR_R;
            2:       step = S_RD0_NAK;
            default: step = S_STOP;
          endcase
        end else begin
          case (int'(idx))
            0:       step = S_START;
            1:       step = S_WADDR_W;
            2:       step = S_WCMD;
            default: step = S_STOP;
          endcase
        end
      end
      XT_BDATA: begin
        if (rd) begin
          case (int'(idx))
            0:       step = S_START;
            1:       step = S_WADDR_W;
            2:       step = S_WCMD;
            3:       step = S_RSTART;
            4:       step = S_WADDR_R;
            5:       step = S_RD0_NAK;
            default: step = S_STOP;
          endcase
        end else begin
          case (int'(idx))
            0:       step = S_START;
            1:       step = S_WADDR_W;
            2:       step = S_WCMD;
            3:       step = S_WD0;
            default: step = S_STOP;
          endcase
        end
      end
      default: begin  // XT_WORD
        if (rd) begin
          case (int'(idx))
            0:       step = S_START;
            1:       step = S_WADDR_W;
            2:       step = S_WCMD;
            3:       step = S_RSTART;
            4:       step = S_WADDR_R;
            5:       step = S_RD0_ACK;
            6:       step = S_RD1_NAK;
            default: step = S_STOP;
          endcase
        end else begin
          case (int'(idx))
            0:       step = S_START;
            1:       step = S_WADDR_W;
            2:       step = S_WCMD;
            3:       step = S_WD0;
            4:       step = S_WD1;
            default: step = S_STOP;
          endcase
        end
      end
    endcase
  end

endmodule

// File: rtl/smb_seq_regs.sv
module smb_seq_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata0,
  input  logic [DATA_W-1:0] wdata1,
  input  logic              we0,
  input  logic              we1,
  input  logic [DATA_W-1:0] rbyte,
  input  logic              set_done,
  input  logic              set_dev,
  input  logic              set_coll,
  output logic [DATA_W-1:0] data0,
  output logic [DATA_W-1:0] data1,
  output logic              done_sts,
  output logic              dev_err_sts,
  output logic              coll_sts
);

  logic [DATA_W-1:0] d0_d, d1_d;
  logic              d0_en, d1_en;
  logic              done_d, dev_d, coll_d;
  logic              sts_en;

  always_comb begin
    d0_en = load | we0;
    d1_en = load | we1;
    d0_d  = load ? wdata0 : rbyte;
    d1_d  = load ? wdata1 : rbyte;
    sts_en = load | set_done | set_dev | set_coll;
    done_d = ~load & (done_sts    | set_done);
    dev_d  = ~load & (dev_err_sts | set_dev);
    coll_d = ~load & (coll_sts    | set_coll);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data0 <= '0;
    end else if (d0_en) begin
      data0 <= d0_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data1 <= '0;
    end else if (d1_en) begin
      data1 <= d1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_sts    <= 1'b0;
      dev_err_sts <= 1'b0;
      coll_sts    <= 1'b0;
    end else if (sts_en) begin
      done_sts    <= done_d;
      dev_err_sts <= dev_d;
      coll_sts    <= coll_d;
    end
  end

endmodule

// File: rtl/smb_seq_ctrl.sv
module smb_seq_ctrl
  import smb_seq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        type_in,
  input  logic              rd_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] cmd_in,
  input  step_t             step,
  input  logic [DATA_W-1:0] d0,
  input  logic [DATA_W-1:0] d1,
  output xact_e             cur_type,
  output logic              cur_rd,
  output logic [STEP_W-1:0] cur_idx,
  input  logic              bm_done,
  input  logic              bm_ack,
  input  logic              bm_arb_lost,
  output logic              bm_req,
  output logic [2:0]        bm_op,
  output logic [DATA_W-1:0] bm_wbyte,
  output logic              bm_rd_nack,
  output logic              busy,
  output logic              load,
  output logic              set_done,
  output logic              set_dev,
  output logic              set_coll,
  output logic              we0,
  output logic              we1
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ESTOP = 2'd2
  } state_e;

  state_e            state_q, state_d;
  logic [STEP_W-1:0] idx_q, idx_d;
  logic              idx_en;
  xact_e             type_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] cmd_q;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    idx_en   = 1'b0;
    load     = 1'b0;
    set_done = 1'b0;
    set_dev  = 1'b0;
    set_coll = 1'b0;
    we0      = 1'b0;
    we1      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d = ST_RUN;
          idx_d   = '0;
          idx_en  = 1'b1;
          load    = 1'b1;
        end
      end
      ST_RUN: begin
        if (bm_done) begin
          if (bm_arb_lost) begin
            set_coll = 1'b1;
            state_d  = (step.op == BOP_STOP) ? ST_IDLE : ST_ESTOP;
          end else if (step.op == BOP_WRITE && !bm_ack) begin
            set_dev = 1'b1;
            state_d = ST_ESTOP;
          end else if (step.op == BOP_STOP) begin
            set_done = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            if (step.op == BOP_READ) begin
              we0 = (step.dst == DST_D0);
              we1 = (step.dst == DST_D1);
            end
            idx_d  = idx_q + STEP_W'(1);
            idx_en = 1'b1;
          end
        end
      end
      ST_ESTOP: begin
        if (bm_done) begin
          set_coll = bm_arb_lost;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= XT_QUICK;
      rd_q   <= 1'b0;
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (load) begin
      type_q <= xact_e'(type_in);
      rd_q   <= rd_in;
      addr_q <= addr_in;
      cmd_q  <= cmd_in;
    end
  end

  // Outputs towards the byte master
  always_comb begin
    bm_req     = (state_q != ST_IDLE);
    busy       = bm_req;
    bm_op      = BOP_IDLE;
    bm_wbyte   = '0;
    bm_rd_nack = 1'b0;
    if (state_q == ST_ESTOP) begin
      bm_op = BOP_STOP;
    end else if (state_q == ST_RUN) begin
      bm_op      = step.op;
      bm_rd_nack = (step.op == BOP_READ) & step.nack;
      case (step.src)
        SRC_ADDR:    bm_wbyte = DATA_W'({addr_q, rd_q});
        SRC_ADDR_WR: bm_wbyte = DATA_W'({addr_q, 1'b0});
        SRC_ADDR_RD: bm_wbyte = DATA_W'({addr_q, 1'b1});
        SRC_CMD:     bm_wbyte = cmd_q;
        SRC_D0:      bm_wbyte = d0;
        SRC_D1:      bm_wbyte = d1;
        default:     bm_wbyte = '0;
      endcase
    end
  end

  assign cur_type = type_q;
  assign cur_rd   = rd_q;
  assign cur_idx  = idx_q;

endmodule

// File: rtl/smbus_xact_seq.sv
module smbus_xact_seq
  import smb_seq_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int MAX_STEPS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        xact_type,
  input  logic              rd_not_wr,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic [DATA_W-1:0] wdata0,
  input  logic [DATA_W-1:0] wdata1,
  output logic [DATA_W-1:0] data0,
  output logic [DATA_W-1:0] data1,
  output logic              busy,
  output logic              done_sts,
  output logic              dev_err_sts,
  output logic              coll_sts,
  output logic              bm_req,
  output logic [2:0]        bm_op,
  output logic [DATA_W-1:0] bm_wbyte,
  output logic              bm_rd_nack,
  input  logic              bm_done,
  input  logic              bm_ack,
  input  logic              bm_arb_lost,
  input  logic [DATA_W-1:0] bm_rbyte
);

  localparam int STEP_W = $clog2(MAX_STEPS);

  xact_e             cur_type;
  logic              cur_rd;
  logic [STEP_W-1:0] cur_idx;
  step_t             cur_step;
  logic              load, set_done, set_dev, set_coll, we0, we1;

  smb_step_decode #(.STEP_W(STEP_W)) u_decode (
    .xtype (cur_type),
    .rd    (cur_rd),
    .idx   (cur_idx),
    .step  (cur_step)
  );

  smb_seq_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STEP_W (STEP_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .type_in     (xact_type),
    .rd_in       (rd_not_wr),
    .addr_in     (slave_addr),
    .cmd_in      (cmd_byte),
    .step        (cur_step),
    .d0          (data0),
    .d1          (data1),
    .cur_type    (cur_type),
    .cur_rd      (cur_rd),
    .cur_idx     (cur_idx),
    .bm_done     (bm_done),
    .bm_ack      (bm_ack),
    .bm_arb_lost (bm_arb_lost),
    .bm_req      (bm_req),
    .bm_op       (bm_op),
    .bm_wbyte    (bm_wbyte),
    .bm_rd_nack  (bm_rd_nack),
    .busy        (busy),
    .load        (load),
    .set_done    (set_done),
    .set_dev     (set_dev),
    .set_coll    (set_coll),
    .we0         (we0),
    .we1         (we1)
  );

  smb_seq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .wdata0      (wdata0),
    .wdata1      (wdata1),
    .we0         (we0),
    .we1         (we1),
    .rbyte       (bm_rbyte),
    .set_done    (set_done),
    .set_dev     (set_dev),
    .set_coll    (set_coll),
    .data0       (data0),
    .data1       (data1),
    .done_sts    (done_sts),
    .dev_err_sts (dev_err_sts),
    .coll_sts    (coll_sts)
  );

endmodule

// File: rtl/smbus_xact_seq_chk.sv
module smbus_xact_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done_sts,
  input logic              dev_err_sts,
  input logic              coll_sts,
  input logic              bm_req,
  input logic [2:0]        bm_op,
  input logic [DATA_W-1:0] bm_wbyte,
  input logic              bm_rd_nack,
  input logic              bm_done,
  input logic              bm_ack,
  input logic              bm_arb_lost
);

  localparam logic [2:0] OP_START = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;
  localparam logic [2:0] OP_STOP  = 3'd5;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bm_req);

  // R2
  first_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bm_op == OP_START);

  // R7
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && bm_done && bm_op == OP_WRITE && !bm_ack && !bm_arb_lost)
      |=> (bm_req && bm_op == OP_STOP && dev_err_sts));

  // R8
  arb_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && bm_done && bm_arb_lost && bm_op != OP_STOP)
      |=> (bm_req && bm_op == OP_STOP && coll_sts));

  // R9
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && bm_done && bm_op == OP_STOP) |=> !busy);

  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_sts && (dev_err_sts || coll_sts)));

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_sts);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && !bm_done)
      |=> (bm_req && $stable(bm_op) && $stable(bm_wbyte) && $stable(bm_rd_nack)));

endmodule

bind smbus_xact_seq smbus_xact_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done_sts    (done_sts),
  .dev_err_sts (dev_err_sts),
  .coll_sts    (coll_sts),
  .bm_req      (bm_req),
  .bm_op       (bm_op),
  .bm_wbyte    (bm_wbyte),
  .bm_rd_nack  (bm_rd_nack),
  .bm_done     (bm_done),
  .bm_ack      (bm_ack),
  .bm_arb_lost (bm_arb_lost)
);

// File: tb/tb_smbus_xact_seq.sv
`timescale 1ns/1ps
module tb_smbus_xact_seq;

  localparam int OP_START  = 1;
  localparam int OP_WRITE  = 2;
  localparam int OP_READ   = 3;
  localparam int OP_RSTART = 4;
  localparam int OP_STOP   = 5;

  logic       clk, rst_n;
  logic       go, rd_not_wr;
  logic [1:0] xact_type;
  logic [6:0] slave_addr;
  logic [7:0] cmd_byte, wdata0, wdata1;
  logic [7:0] data0, data1;
  logic       busy, done_sts, dev_err_sts, coll_sts;
  logic       bm_req, bm_rd_nack;
  logic [2:0] bm_op;
  logic [7:0] bm_wbyte;
  logic       bm_done, bm_ack, bm_arb_lost;
  logic [7:0] bm_rbyte;

  smbus_xact_seq dut (
    .clk(clk), .rst_n(rst_n), .go(go), .xact_type(xact_type),
    .rd_not_wr(rd_not_wr), .slave_addr(slave_addr), .cmd_byte(cmd_byte),
    .wdata0(wdata0), .wdata1(wdata1), .data0(data0), .data1(data1),
    .busy(busy), .done_sts(done_sts), .dev_err_sts(dev_err_sts),
    .coll_sts(coll_sts), .bm_req(bm_req), .bm_op(bm_op),
    .bm_wbyte(bm_wbyte), .bm_rd_nack(bm_rd_nack), .bm_done(bm_done),
    .bm_ack(bm_ack), .bm_arb_lost(bm_arb_lost), .bm_rbyte(bm_rbyte)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // ---------------- byte master model ----------------
  int         model_lat = 1;
  int         lat = 0;
  int         nlog = 0;
  int         inj_nack_at = -1;
  int         inj_arb_at = -1;
  int         rd_cnt = 0;
  int         hold_err = 0;
  logic [7:0] rd_src [0:1];
  int         op_log [0:15];
  logic [7:0] byte_log [0:15];
  logic       nack_log [0:15];
  logic [2:0] seen_op;
  logic [7:0] seen_byte;
  logic       seen_nack;

  always @(negedge clk) begin
    bm_done     <= 1'b0;
    bm_ack      <= 1'b1;
    bm_arb_lost <= 1'b0;
    if (!rst_n) begin
      lat <= 0;
    end else if (bm_req && !bm_done) begin
      if (lat == 0) begin
        seen_op   <= bm_op;
        seen_byte <= bm_wbyte;
        seen_nack <= bm_rd_nack;
      end else if (bm_op !== seen_op || bm_wbyte !== seen_byte || bm_rd_nack !== seen_nack) begin
        hold_err <= hold_err + 1;
      end
      if (lat >= model_lat) begin
        lat     <= 0;
        bm_done <= 1'b1;
        if (nlog < 16) begin
          op_log[nlog]   <= int'(bm_op);
          byte_log[nlog] <= bm_wbyte;
          nack_log[nlog] <= bm_rd_nack;
        end
        if (int'(bm_op) == OP_WRITE && nlog == inj_nack_at) bm_ack <= 1'b0;
        if (nlog == inj_arb_at) bm_arb_lost <= 1'b1;
        if (int'(bm_op) == OP_READ) begin
          bm_rbyte <= rd_src[rd_cnt % 2];
          rd_cnt   <= rd_cnt + 1;
        end
        nlog <= nlog + 1;
      end else begin
        lat <= lat + 1;
      end
    end
  end

  // ---------------- helpers ----------------
  int         exp_n;
  int         exp_op [0:15];
  logic [7:0] exp_byte [0:15];
  logic       exp_nack [0:15];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic exp_clear();
    exp_n = 0;
  endtask

  task automatic exp_push(input int op, input logic [7:0] b, input logic nk);
    exp_op[exp_n]   = op;
    exp_byte[exp_n] = b;
    exp_nack[exp_n] = nk;
    exp_n++;
  endtask

  task automatic cmp_log(input string tag);
    chk(nlog == exp_n, {tag, " op count"}, nlog, exp_n);
    for (int i = 0; i < exp_n && i < nlog; i++) begin
      chk(op_log[i] == exp_op[i], {tag, " op"}, op_log[i], exp_op[i]);
      if (exp_op[i] == OP_WRITE)
        chk(byte_log[i] == exp_byte[i], {tag, " write byte"}, byte_log[i], exp_byte[i]);
      if (exp_op[i] == OP_READ)
        chk(nack_log[i] == exp_nack[i], {tag, " read nack"}, nack_log[i], exp_nack[i]);
    end
  endtask

  task automatic start_go(input int t, input logic rd, input logic [6:0] a,
                          input logic [7:0] c, input logic [7:0] w0, input logic [7:0] w1);
    @(negedge clk);
    nlog = 0; rd_cnt = 0;
    xact_type = 2'(t); rd_not_wr = rd; slave_addr = a;
    cmd_byte = c; wdata0 = w0; wdata1 = w1; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, {tag, " busy cleared"}, busy, 0);
  endtask

  task automatic run_ok(input string tag, input int t, input logic rd, input logic [6:0] a,
                        input logic [7:0] c, input logic [7:0] w0, input logic [7:0] w1);
    start_go(t, rd, a, c, w0, w1);
    wait_idle(tag);
    cmp_log(tag);
    chk(done_sts && !dev_err_sts && !coll_sts, {tag, " R9 done status"},
        {done_sts, dev_err_sts, coll_sts}, 3'b100);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(!busy && !bm_req, "R1 idle after reset", {busy, bm_req}, 0);
    chk(!done_sts && !dev_err_sts && !coll_sts, "R1 status clear",
        {done_sts, dev_err_sts, coll_sts}, 0);
    chk(data0 == 8'h00 && data1 == 8'h00, "R1 data clear", {data0, data1}, 0);
  endtask

  task automatic t_quick();
    exp_clear();
    exp_push(OP_START, 0, 0); exp_push(OP_WRITE, 8'h55, 0); exp_push(OP_STOP, 0, 0);
    run_ok("R2 quick read-flag", 0, 1'b1, 7'h2A, 8'h00, 8'h00, 8'h00);
    exp_clear();
    exp_push(OP_START, 0, 0); exp_push(OP_WRITE, 8'h54, 0); exp_push(OP_STOP, 0, 0);
    run_ok("R2 quick write-flag", 0, 1'b0, 7'h2A, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_byte();
    exp_clear();
    exp_push(OP_START, 0, 0); exp_push(OP_WRITE, 8'hA0, 0);
    exp_push(OP_WRITE, 8'hA5, 0); exp_push(OP_STOP, 0, 0);
    run_ok("R3 byte write", 1, 1'b0, 7'h50, 8'hA5, 8'h00, 8'h00);
    rd_src[0] = 8'h3C;
    exp_clear();
    exp_push(OP_START, 0, 0); exp_push(OP_WRITE, 8'hA1, 0);
    exp_push(OP_READ, 0, 1'b1); exp_push(OP_STOP, 0, 0);
    run_ok("R3 byte read", 1, 1'b1, 7'h50, 8'h99, 8'hEE, 8'h00);
    chk(data0 == 8'h3C, "R3 byte read data0", data0, 8'h3C);
  endtask

  task automatic t_bdata_wr();
    exp_clear();
    exp_push(OP_START, 0, 0); exp_push(OP_WRITE, 8'h22, 0);
    exp_push(OP_WRITE, 8'h11, 0); exp_push(OP_WRITE, 8'h5A, 0); exp_push(OP_STOP, 0, 0);
    run_ok("R4 byte-data write", 2, 1'b0, 7'h11, 8'h11, 8'h5A, 8'h00);
  endtask

  task automatic t_bdata_rd();
    rd_src[0] = 8'hC3;
    exp_clear();
    exp_push(OP_START, 0, 0); exp_push(OP_WRITE, 8'h6A, 0);
    exp_push(OP_WRITE, 8'h07, 0); exp_push(OP_RSTART, 0, 0);
    exp_push(OP_WRITE, 8'h6B, 0); exp_push(OP_READ, 0, 1'b1); exp_push(OP_STOP, 0, 0);
    run_ok("R5 byte-data read", 2, 1'b1, 7'h35, 8'h07, 8'h00, 8'h77);
    chk(data0 == 8'hC3, "R5 byte-data read data0", data0, 8'hC3);
    chk(data1 == 8'h77, "R5 data1 untouched", data1, 8'h77);
  endtask

  task automatic t_word();
    exp_clear();
    exp_push(OP_START, 0, 0); exp_push(OP_WRITE, 8'h90, 0);
    exp_push(OP_WRITE, 8'h4E, 0); exp_push(OP_WRITE, 8'hCD, 0);
    exp_push(OP_WRITE, 8'hAB, 0); exp_push(OP_STOP, 0, 0);
    run_ok("R6 word write", 3, 1'b0, 7'h48, 8'h4E, 8'hCD, 8'hAB);
    rd_src[0] = 8'h12; rd_src[1] = 8'h34;
    exp_clear();
    exp_push(OP_START, 0, 0); exp_push(OP_WRITE, 8'h90, 0);
    exp_push(OP_WRITE, 8'h02, 0); exp_push(OP_RSTART, 0, 0);
    exp_push(OP_WRITE, 8'h91, 0); exp_push(OP_READ, 0, 1'b0);
    exp_push(OP_READ, 0, 1'b1); exp_push(OP_STOP, 0, 0);
    run_ok("R6 word read", 3, 1'b1, 7'h48, 8'h02, 8'hFF, 8'hFF);
    chk(data0 == 8'h12, "R6 word read low byte", data0, 8'h12);
    chk(data1 == 8'h34, "R6 word read high byte", data1, 8'h34);
  endtask

  task automatic t_nack();
    inj_nack_at = 2;
    exp_clear();
    exp_push(OP_START, 0, 0); exp_push(OP_WRITE, 8'h90, 0);
    exp_push(OP_WRITE, 8'h4E, 0); exp_push(OP_STOP, 0, 0);
    start_go(3, 1'b0, 7'h48, 8'h4E, 8'hCD, 8'hAB);
    wait_idle("R7 nack");
    inj_nack_at = -1;
    cmp_log("R7 nack");
    chk(dev_err_sts && !done_sts && !coll_sts, "R7 device error status",
        {done_sts, dev_err_sts, coll_sts}, 3'b010);
  endtask

  task automatic t_arb();
    inj_arb_at = 1;
    exp_clear();
    exp_push(OP_START, 0, 0); exp_push(OP_WRITE, 8'h22, 0); exp_push(OP_STOP, 0, 0);
    start_go(2, 1'b0, 7'h11, 8'h33, 8'h44, 8'h00);
    wait_idle("R8 arbitration");
    inj_arb_at = -1;
    cmp_log("R8 arbitration");
    chk(coll_sts && !done_sts && !dev_err_sts, "R8 collision status",
        {done_sts, dev_err_sts, coll_sts}, 3'b001);
    // arbitration lost on the stop itself: no extra stop
    inj_arb_at = 2;
    exp_clear();
    exp_push(OP_START, 0, 0); exp_push(OP_WRITE, 8'h23, 0); exp_push(OP_STOP, 0, 0);
    start_go(0, 1'b1, 7'h11, 8'h00, 8'h00, 8'h00);
    wait_idle("R8 lost on stop");
    inj_arb_at = -1;
    cmp_log("R8 lost on stop");
    chk(coll_sts && !done_sts, "R8 collision on stop", {done_sts, coll_sts}, 2'b01);
  endtask

  task automatic t_clear_on_go();
    start_go(0, 1'b0, 7'h01, 8'h00, 8'h66, 8'h99);
    chk(!coll_sts && !dev_err_sts && !done_sts, "R9 status cleared on accept",
        {done_sts, dev_err_sts, coll_sts}, 0);
    chk(data0 == 8'h66 && data1 == 8'h99, "R9 data loaded on accept", {data0, data1}, 16'h6699);
    wait_idle("R9 clear");
    chk(done_sts, "R9 done after clean stop", done_sts, 1);
  endtask

  task automatic t_ignore_go();
    model_lat = 3;
    exp_clear();
    exp_push(OP_START, 0, 0); exp_push(OP_WRITE, 8'h90, 0);
    exp_push(OP_WRITE, 8'h4E, 0); exp_push(OP_WRITE, 8'hCD, 0);
    exp_push(OP_WRITE, 8'hAB, 0); exp_push(OP_STOP, 0, 0);
    start_go(3, 1'b0, 7'h48, 8'h4E, 8'hCD, 8'hAB);
    repeat (4) @(negedge clk);
    xact_type = 2'd0; rd_not_wr = 1'b1; slave_addr = 7'h7F;
    wdata0 = 8'h00; wdata1 = 8'h00; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    wait_idle("R10 go while busy");
    cmp_log("R10 go while busy");
    chk(data0 == 8'hCD && data1 == 8'hAB, "R10 data untouched", {data0, data1}, 16'hCDAB);
    chk(hold_err == 0, "R11 request held until done", hold_err, 0);
    model_lat = 1;
  endtask

  // ---------------- main ----------------
  bit finished = 1'b0;

  initial begin
    rst_n = 1'b0; go = 1'b0; xact_type = 2'd0; rd_not_wr = 1'b0;
    slave_addr = '0; cmd_byte = '0; wdata0 = '0; wdata1 = '0;
    bm_rbyte = '0; rd_src[0] = '0; rd_src[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_quick();
    t_byte();
    t_bdata_wr();
    t_bdata_rd();
    t_word();
    t_nack();
    t_arb();
    t_clear_on_go();
    t_ignore_go();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule